// File: doc/BRIEF.md
# Set-Associative Branch Target Predictor

This block predicts the direction and destination of branches for an instruction fetch unit. It keeps a table of recently taken branches, organised as several ways per set. Each entry holds an address tag, a target address and a two-bit saturating confidence counter. The fetch side presents an address and gets back, in the same cycle, whether that address is a known branch, whether it is predicted taken, and where it is predicted to go.

Once a branch has executed, the back end reports its address, whether it was taken and its real destination. A branch that is not yet in the table gets an entry only if it was taken, so a branch that has never been taken costs no storage and is predicted not taken. A branch that already has an entry moves its counter one step toward the observed outcome. A global enable input lets the fetch unit fall back to a fixed not-taken prediction without losing what the table has learned.

Top module: `btb_predictor`

## Requirements
- R1: With default parameters the table has 4 ways of 128 sets. The set index is address bits [8:2], the tag is bits [31:9], and bits [1:0] of the fetch and resolve addresses have no effect.
- R2: A resolution that misses the table creates an entry only when it is taken. A not-taken miss leaves the table unchanged, so a later lookup of that address still misses.
- R3: A lookup that matches no valid entry, or a lookup with fetch_valid low, gives pred_hit = 0 and pred_taken = 0.
- R4: A new entry starts in the weakly-taken state and holds the resolved target, so the next lookup of that address predicts taken and returns that target.
- R5: The counter encoding is 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken. A hit predicts taken for 2 or 3. A taken resolution adds one and a not-taken resolution subtracts one, and the counter saturates at 3 and at 0.
- R6: While pred_en is low, pred_taken is 0 for every lookup. pred_hit still reports table matches, and table contents are preserved.
- R7: A taken resolution that hits an entry rewrites its target. A not-taken resolution that hits keeps the stored target and never removes the entry.
- R8: An allocation fills the lowest-numbered invalid way of the set. When all ways are valid it replaces the way named by that set's round-robin pointer, which then advances by one with wrap-around.
- R9: A lookup reflects the table as it stood before the current edge. A resolution presented in one cycle is visible to lookups from the next cycle on.
- R10: A synchronous reset invalidates every entry and returns every round-robin pointer to way 0.
- R11: pred_target is the stored target with bits [1:0] forced to zero while pred_taken is 1, and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_en | input | 1 | Enables dynamic prediction; when low every prediction is not taken |
| fetch_valid | input | 1 | A lookup is presented this cycle |
| fetch_pc | input | ADDR_W | Fetch address to look up |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Branch predicted taken |
| pred_target | output | ADDR_W | Predicted target address (zero when not taken) |
| res_valid | input | 1 | A branch resolution is presented this cycle |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome of the branch |
| res_target | input | ADDR_W | Actual target of the branch |

## Verification
The three prediction outputs are combinational from the registered table, so a lookup result is due in the same cycle its fetch address is presented, while a resolution changes what lookups see only from the cycle after the edge that samples it. The bench drives every input one nanosecond after a rising edge and compares outputs at the following falling edge, so a lookup is checked in the cycle it is issued and a lookup that follows a resolution task is checked one edge after the write. One case presents a resolution and a lookup of the same new address in one cycle and expects a miss, then a hit one cycle later.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Two-bit confidence counter states
  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_t;

  // Saturating step toward the observed outcome
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    ctr_t c;
    ctr_t n;
    c = ctr_t'(cur);
    n = c;
    case (c)
      CTR_SNT: n = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: n = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  n = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  n = taken ? CTR_ST  : CTR_WT;
      default: n = CTR_WT;
    endcase
    return n;
  endfunction

  // Either taken state predicts taken
  function automatic logic ctr_predicts_taken(input logic [1:0] cur);
    return (ctr_t'(cur) == CTR_WT) || (ctr_t'(cur) == CTR_ST);
  endfunction

endpackage

// File: rtl/btb_way.sv
module btb_way #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 23,
  parameter int TGT_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [IDX_W-1:0] rs_idx,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic [1:0]       wr_ctr,
  output logic             lk_valid,
  output logic [TAG_W-1:0] lk_tag,
  output logic [TGT_W-1:0] lk_tgt,
  output logic [1:0]       lk_ctr,
  output logic             rs_valid,
  output logic [TAG_W-1:0] rs_tag,
  output logic [TGT_W-1:0] rs_tgt,
  output logic [1:0]       rs_ctr
);

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [TGT_W-1:0] tgt_q [SETS];
  logic [1:0]       ctr_q [SETS];

  // Only the valid bits are reset; payload is qualified by them
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[rs_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rst) begin
      tag_q[rs_idx] <= wr_tag;
      tgt_q[rs_idx] <= wr_tgt;
      ctr_q[rs_idx] <= wr_ctr;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];
  assign lk_tgt   = tgt_q[lk_idx];
  assign lk_ctr   = ctr_q[lk_idx];

  assign rs_valid = valid_q[rs_idx];
  assign rs_tag   = tag_q[rs_idx];
  assign rs_tgt   = tgt_q[rs_idx];
  assign rs_ctr   = ctr_q[rs_idx];

endmodule

// File: rtl/btb_select.sv
module btb_select #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 23,
  parameter int TGT_W = 30
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][TGT_W-1:0] way_tgt,
  input  logic [WAYS-1:0][1:0]       way_ctr,
  input  logic [TAG_W-1:0]           key_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [TGT_W-1:0]           sel_tgt,
  output logic [1:0]                 sel_ctr
);

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = way_valid[g] && (way_tag[g] == key_tag);
    end
  endgenerate

  assign hit = |hit_vec;

  // One-hot AND-OR mux; at most one way matches a given tag
  always_comb begin
    sel_tgt = '0;
    sel_ctr = '0;
    for (int w = 0; w < WAYS; w++) begin
      sel_tgt = sel_tgt | (way_tgt[w] & {TGT_W{hit_vec[w]}});
      sel_ctr = sel_ctr | (way_ctr[w] & {2{hit_vec[w]}});
    end
  end

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAYS-1:0]  set_valid,
  input  logic             alloc,
  output logic [WAYS-1:0]  victim_oh,
  output logic             set_full
);

  logic [WAY_W-1:0] rr_q [SETS];
  logic             found;

  assign set_full = &set_valid;

  // Lowest invalid way first, round-robin pointer when the set is full
  always_comb begin
    victim_oh = '0;
    found     = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!set_valid[w] && !found) begin
        victim_oh[w] = 1'b1;
        found        = 1'b1;
      end
    end
    if (!found) begin
      victim_oh[rr_q[set_idx]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
      end
    end else if (alloc && set_full) begin
      rr_q[set_idx] <= rr_q[set_idx] + WAY_W'(1);
    end
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 512,
  parameter int WAYS    = 4,
  parameter int ALIGN   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_en,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target
);

  import btb_pkg::*;

  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN;
  localparam int TGT_W = ADDR_W - ALIGN;

  // Address split
  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_key, rs_key;
  logic [TGT_W-1:0] res_tgt_w;
  logic             unused_low;

  assign lk_idx    = fetch_pc[ALIGN +: IDX_W];
  assign lk_key    = fetch_pc[ADDR_W-1 -: TAG_W];
  assign rs_idx    = res_pc[ALIGN +: IDX_W];
  assign rs_key    = res_pc[ADDR_W-1 -: TAG_W];
  assign res_tgt_w = res_target[ADDR_W-1 -: TGT_W];
  assign unused_low = ^{fetch_pc[ALIGN-1:0], res_pc[ALIGN-1:0], res_target[ALIGN-1:0]};

  // Per-way read data
  logic [WAYS-1:0]            lk_v, rs_v;
  logic [WAYS-1:0][TAG_W-1:0] lk_t, rs_t;
  logic [WAYS-1:0][TGT_W-1:0] lk_g, rs_g;
  logic [WAYS-1:0][1:0]       lk_c, rs_c;

  // Named internal events
  logic [WAYS-1:0]  lk_hit_vec, rs_hit_vec, victim_oh, way_wr;
  logic             lk_hit, rs_hit, set_full;
  logic             upd_fire, alloc_fire;
  logic [TGT_W-1:0] lk_sel_tgt, rs_sel_tgt, wr_tgt;
  logic [1:0]       lk_sel_ctr, rs_sel_ctr, wr_ctr;

  assign upd_fire   = res_valid && rs_hit;
  assign alloc_fire = res_valid && !rs_hit && res_taken;

  // Existing entry: step counter, take new target only on taken outcome.
  // New entry: weakly taken with the resolved target.
  assign wr_ctr = upd_fire ? ctr_step(rs_sel_ctr, res_taken) : 2'(CTR_WT);
  assign wr_tgt = (upd_fire && !res_taken) ? rs_sel_tgt : res_tgt_w;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_way
      assign way_wr[g] = (upd_fire && rs_hit_vec[g]) || (alloc_fire && victim_oh[g]);

      btb_way #(
        .SETS (SETS),
        .IDX_W(IDX_W),
        .TAG_W(TAG_W),
        .TGT_W(TGT_W)
      ) u_way (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (lk_idx),
        .rs_idx  (rs_idx),
        .wr_en   (way_wr[g]),
        .wr_tag  (rs_key),
        .wr_tgt  (wr_tgt),
        .wr_ctr  (wr_ctr),
        .lk_valid(lk_v[g]),
        .lk_tag  (lk_t[g]),
        .lk_tgt  (lk_g[g]),
        .lk_ctr  (lk_c[g]),
        .rs_valid(rs_v[g]),
        .rs_tag  (rs_t[g]),
        .rs_tgt  (rs_g[g]),
        .rs_ctr  (rs_c[g])
      );
    end
  endgenerate

  btb_select #(.WAYS(WAYS), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_lk_sel (
    .way_valid(lk_v),
    .way_tag  (lk_t),
    .way_tgt  (lk_g),
    .way_ctr  (lk_c),
    .key_tag  (lk_key),
    .hit_vec  (lk_hit_vec),
    .hit      (lk_hit),
    .sel_tgt  (lk_sel_tgt),
    .sel_ctr  (lk_sel_ctr)
  );

  btb_select #(.WAYS(WAYS), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_rs_sel (
    .way_valid(rs_v),
    .way_tag  (rs_t),
    .way_tgt  (rs_g),
    .way_ctr  (rs_c),
    .key_tag  (rs_key),
    .hit_vec  (rs_hit_vec),
    .hit      (rs_hit),
    .sel_tgt  (rs_sel_tgt),
    .sel_ctr  (rs_sel_ctr)
  );

  btb_victim #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .set_idx  (rs_idx),
    .set_valid(rs_v),
    .alloc    (alloc_fire),
    .victim_oh(victim_oh),
    .set_full (set_full)
  );

  // Prediction outputs
  assign pred_hit    = fetch_valid && lk_hit;
  assign pred_taken  = pred_hit && pred_en && ctr_predicts_taken(lk_sel_ctr);
  assign pred_target = pred_taken ? {lk_sel_tgt, {ALIGN{1'b0}}} : '0;

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              pred_en,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_target,
  input logic              res_valid,
  input logic              res_taken,
  input logic [WAYS-1:0]   lk_hit_vec,
  input logic [WAYS-1:0]   rs_hit_vec,
  input logic [WAYS-1:0]   victim_oh,
  input logic              alloc_fire,
  input logic              upd_fire
);

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec) && $onehot0(rs_hit_vec)); // R2

  AST_NT_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_taken) |-> !alloc_fire); // R2

  AST_ALLOC_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |-> (rs_hit_vec == '0)); // R2

  AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |-> $onehot(victim_oh)); // R8

  AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> !pred_taken); // R3

  AST_DISABLED_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    !pred_en |-> !pred_taken); // R6

  AST_TARGET_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> (pred_target == '0)); // R11

  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pred_target[1:0] == 2'b00); // R11

  AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (rst)
    !(alloc_fire && upd_fire)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !pred_hit); // R10

endmodule

bind btb_predictor btb_predictor_chk #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pred_en    (pred_en),
  .pred_hit   (pred_hit),
  .pred_taken (pred_taken),
  .pred_target(pred_target),
  .res_valid  (res_valid),
  .res_taken  (res_taken),
  .lk_hit_vec (lk_hit_vec),
  .rs_hit_vec (rs_hit_vec),
  .victim_oh  (victim_oh),
  .alloc_fire (alloc_fire),
  .upd_fire   (upd_fire)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pred_en = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_target;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  btb_predictor dut (
    .clk(clk), .rst(rst), .pred_en(pred_en),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target)
  );

  // Reference table built from the requirements
  bit        mv   [128][4];
  bit [22:0] mtag [128][4];
  bit [29:0] mtgt [128][4];
  int        mctr [128][4];
  int        mptr [128];

  // Scoreboard queues
  bit          q_hit [$];
  bit          q_tk  [$];
  logic [31:0] q_tgt [$];
  string       q_req [$];

  function automatic logic [31:0] mk(input int tag, input int idx);
    return {tag[22:0], idx[6:0], 2'b00};
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < 128; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < 4; w++) mv[s][w] = 0;
    end
  endfunction

  function automatic void model_lookup(input logic [31:0] pc, output bit h,
                                       output bit t, output logic [31:0] tg);
    int s;
    s = int'(pc[8:2]);
    h = 0; t = 0; tg = '0;
    for (int w = 0; w < 4; w++) begin
      if (mv[s][w] && mtag[s][w] == pc[31:9]) begin
        h = 1;
        if (pred_en && mctr[s][w] >= 2) begin
          t = 1;
          tg = {mtgt[s][w], 2'b00};
        end
      end
    end
  endfunction

  function automatic void model_resolve(input logic [31:0] pc, input bit tk,
                                        input logic [31:0] tgt);
    int s, hw, v;
    s = int'(pc[8:2]);
    hw = -1;
    for (int w = 0; w < 4; w++)
      if (mv[s][w] && mtag[s][w] == pc[31:9]) hw = w;
    if (hw >= 0) begin
      if (tk) begin
        if (mctr[s][hw] < 3) mctr[s][hw]++;
        mtgt[s][hw] = tgt[31:2];
      end else if (mctr[s][hw] > 0) begin
        mctr[s][hw]--;
      end
    end else if (tk) begin
      v = -1;
      for (int w = 0; w < 4; w++)
        if (!mv[s][w] && v < 0) v = w;
      if (v < 0) begin
        v = mptr[s];
        mptr[s] = (mptr[s] + 1) % 4;
      end
      mv[s][v] = 1; mtag[s][v] = pc[31:9];
      mtgt[s][v] = tgt[31:2]; mctr[s][v] = 2;
    end
  endfunction

  task automatic push_expect(input logic [31:0] pc, input string req);
    bit h, t;
    logic [31:0] tg;
    model_lookup(pc, h, t, tg);
    q_hit.push_back(h); q_tk.push_back(t); q_tgt.push_back(tg); q_req.push_back(req);
  endtask

  // Driver: one lookup, checked in the same cycle by the monitor
  task automatic lookup(input logic [31:0] pc, input string req);
    push_expect(pc, req);
    fetch_valid = 1'b1;
    fetch_pc = pc;
    @(posedge clk); #1;
    fetch_valid = 1'b0;
  endtask

  // Driver: one resolution, written at the next edge
  task automatic resolve(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
    @(posedge clk); #1;
    res_valid = 1'b0;
    model_resolve(pc, tk, tgt);
  endtask

  // Resolution and lookup of the same address in one cycle (R9)
  task automatic resolve_with_lookup(input logic [31:0] pc, input logic [31:0] tgt);
    push_expect(pc, "R9");
    res_valid = 1'b1; res_pc = pc; res_taken = 1'b1; res_target = tgt;
    fetch_valid = 1'b1; fetch_pc = pc;
    @(posedge clk); #1;
    res_valid = 1'b0; fetch_valid = 1'b0;
    model_resolve(pc, 1'b1, tgt);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    model_clear();
  endtask

  // Monitor: pop the expected item and compare at the falling edge
  always @(negedge clk) begin
    if (!rst && fetch_valid) begin
      if (q_hit.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: lookup with no expected item");
      end else begin
        bit h, t;
        logic [31:0] tg;
        string r;
        h = q_hit.pop_front(); t = q_tk.pop_front();
        tg = q_tgt.pop_front(); r = q_req.pop_front();
        checks++;
        if (pred_hit !== h) begin
          errors++;
          $display("FAIL %s pc=%h pred_hit actual %b expected %b", r, fetch_pc, pred_hit, h);
        end
        checks++;
        if (pred_taken !== t) begin
          errors++;
          $display("FAIL %s pc=%h pred_taken actual %b expected %b", r, fetch_pc, pred_taken, t);
        end
        checks++;
        if (pred_target !== tg) begin
          errors++;
          $display("FAIL %s pc=%h pred_target actual %h expected %h", r, fetch_pc, pred_target, tg);
        end
      end
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] a, b;

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R10: reset state, nothing presented
    checks++;
    if (pred_hit !== 1'b0 || pred_taken !== 1'b0 || pred_target !== '0) begin
      errors++;
      $display("FAIL R10 reset outputs actual %b %b %h expected 0 0 0",
               pred_hit, pred_taken, pred_target);
    end

    a = mk(100, 3);
    lookup(a, "R3");                        // empty table misses
    resolve(a, 1'b0, 32'h0001_0040);
    lookup(a, "R2");                        // not-taken miss allocates nothing
    resolve(a, 1'b1, 32'h0001_0043);        // low target bits dropped
    lookup(a, "R4");                        // weakly taken, target stored
    lookup(a | 32'h1, "R1");                // low address bits ignored
    lookup(a | 32'h3, "R1");
    lookup(mk(101, 3), "R1");               // other tag, same set
    lookup(mk(100, 4), "R1");               // same tag, other set

    // R5: counter walk, both saturation ends
    resolve(a, 1'b0, 32'h0);  lookup(a, "R5");   // 1: not taken, still hits
    resolve(a, 1'b0, 32'h0);  lookup(a, "R5");   // 0
    resolve(a, 1'b0, 32'h0);  lookup(a, "R5");   // stays 0, entry kept (R7)
    resolve(a, 1'b1, 32'h0002_0000); lookup(a, "R5"); // 1
    resolve(a, 1'b1, 32'h0002_0000); lookup(a, "R5"); // 2 taken
    resolve(a, 1'b1, 32'h0002_0000); lookup(a, "R5"); // 3
    resolve(a, 1'b1, 32'h0002_0000); lookup(a, "R5"); // stays 3
    resolve(a, 1'b0, 32'h0);  lookup(a, "R5");   // 2 still taken

    // R7: target rewrite on taken hit, kept on not-taken hit
    resolve(a, 1'b1, 32'h0003_1000); lookup(a, "R7");
    resolve(a, 1'b0, 32'h0004_0000); lookup(a, "R7");
    lookup(a, "R11");

    // R6: disabled prediction keeps hit, forces not taken
    pred_en = 1'b0;
    lookup(a, "R6");
    pred_en = 1'b1;
    lookup(a, "R6");

    // R9: same-cycle lookup sees old table
    b = mk(200, 9);
    resolve_with_lookup(b, 32'h0005_0000);
    lookup(b, "R9");

    // R8: fill one set, then round-robin replacement
    for (int i = 1; i <= 4; i++) resolve(mk(i, 20), 1'b1, 32'h0006_0000 + 32'(i * 16));
    for (int i = 1; i <= 4; i++) lookup(mk(i, 20), "R8");
    resolve(mk(5, 20), 1'b1, 32'h0007_0000);
    lookup(mk(1, 20), "R8");
    lookup(mk(5, 20), "R8");
    resolve(mk(6, 20), 1'b1, 32'h0007_1000);
    lookup(mk(2, 20), "R8");
    lookup(mk(3, 20), "R8");
    resolve(mk(1, 20), 1'b0, 32'h0);        // not-taken miss in a full set
    lookup(mk(1, 20), "R2");
    lookup(mk(3, 20), "R2");

    // R10: mid-run reset clears entries and pointers
    do_reset();
    lookup(a, "R10");
    lookup(b, "R10");
    for (int i = 7; i <= 11; i++) resolve(mk(i, 20), 1'b1, 32'h0008_0000 + 32'(i * 16));
    lookup(mk(7, 20), "R10");
    lookup(mk(8, 20), "R10");
    lookup(mk(11, 20), "R10");

    fetch_valid = 1'b0;
    lookup(mk(11, 20), "R3");
    // R3: fetch_valid low gives no hit
    fetch_pc = mk(11, 20);
    #5;
    checks++;
    if (pred_hit !== 1'b0 || pred_taken !== 1'b0) begin
      errors++;
      $display("FAIL R3 idle fetch actual %b %b expected 0 0", pred_hit, pred_taken);
    end

    @(posedge clk); #1;
    checks++;
    if (q_hit.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expected items left, expected 0", q_hit.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule